// File: doc/BRIEF.md
# Random Filler Instruction Injector

This block sits between instruction fetch and decode. It normally passes the fetched instruction stream straight through: valid, ready, instruction word and PC. It adds no register and no latency on that path. When software turns injection on, the block sometimes starts a burst of harmless filler instructions at moments chosen from an external random word. During a burst, it holds fetch back without losing anything. Each filler is either a no-op or a branch whose target is its own PC. Neither kind changes architectural state, so the power profile of the running code is blurred while program results stay the same.

A 4-bit rate field sets how often bursts start on average. A burst can start on any cycle in which decode could take an instruction. It starts when the lowest `rate` bits of the random word are all zero, so each eligible cycle starts a burst with probability 2^-rate. Further random bits choose the burst length (1 to 8 slots) and the kind of each slot. Dropping the enable or raising the sleep indication prevents new bursts. Either one also cuts a running burst short at the next slot boundary. After a burst, the held fetched instruction is issued with its PC unchanged.

Top module: `filler_injector`

## Requirements
- R1: After reset is released, no burst is in progress. Until a burst starts, dec_valid, dec_instr and dec_pc follow the fetch side, and fetch_ready follows dec_ready.
- R2: While inj_en is 0 and no burst is running, the outputs equal the fetch-side inputs in the same cycle, and fetch_ready equals dec_ready.
- R3: A burst starts in a cycle when all of these hold: inj_en is 1, sleep_req is 0, fetch_valid is 1, dec_ready is 1, no burst is running, and bits [inj_rate-1:0] of rnd_bits[14:0] are all zero. A rate of 0 starts a burst in every such cycle. The first filler is presented in that same cycle.
- R4: The burst length in slots is rnd_bits[17:15]+1, sampled in the start cycle. A slot ends when its filler is accepted (dec_valid and dec_ready both 1).
- R5: Slot kind 0 gives NOP_WORD and kind 1 gives BTS_WORD. The first slot's kind is rnd_bits[18] in the start cycle. The second slot's kind is rnd_bits[19] in the start cycle. Each later slot takes rnd_bits[18] from the cycle in which the previous slot was accepted.
- R6: Every filler is presented with dec_valid 1 and dec_pc equal to the fetch_pc being held, so a branch-to-self filler targets the PC of the pending instruction.
- R7: fetch_ready is 0 in every cycle that presents a filler. The held fetched instruction and its PC are then issued unchanged.
- R8: No burst starts while sleep_req is 1.
- R9: If inj_en is 0 or sleep_req is 1 in the cycle a filler is accepted, the burst ends after that slot and the fetch stream resumes.
- R10: While a filler is presented and dec_ready is 0, the same filler stays on the outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetched instruction present |
| fetch_ready | output | 1 | Fetch side may advance |
| fetch_instr | input | 32 | Fetched instruction word |
| fetch_pc | input | 32 | PC of the fetched instruction |
| rnd_bits | input | 20 | Random word, a fresh value each cycle |
| inj_en | input | 1 | Injection enable |
| inj_rate | input | 4 | Average-rate exponent |
| sleep_req | input | 1 | Sleep indication; blocks injection |
| dec_valid | output | 1 | Instruction presented to decode |
| dec_ready | input | 1 | Decode accepts |
| dec_instr | output | 32 | Instruction to decode |
| dec_pc | output | 32 | PC to decode |

## Verification
The bench builds the block with its default parameters: 32-bit words, 4-bit rate, and bursts of up to eight slots. With these, the full random-word layout is driven, from rate 0, which bursts on every eligible cycle, up to rate 15. At rate 15, starts are forced by clearing the trigger field, so maximum-length bursts and mixed slot kinds occur often. Random stalls on decode and gaps on fetch, together with enable and sleep toggled in the middle of bursts, exercise held fillers and early burst ends.

// File: rtl/inj_pkg.sv
package inj_pkg;
  typedef enum logic {ST_PASS = 1'b0, ST_FILL = 1'b1} inj_state_e;
  localparam logic KIND_NOP = 1'b0;
  localparam logic KIND_BTS = 1'b1;
endpackage

// File: rtl/inj_trigger.sv
module inj_trigger #(
  parameter int RATE_W = 4,
  localparam int TRIG_W = (1 << RATE_W) - 1
) (
  input  logic [RATE_W-1:0] rate,
  input  logic [TRIG_W-1:0] rnd_trig,
  output logic              hit
);
  logic [TRIG_W-1:0] mask;

  // bit i takes part in the compare when i < rate
  for (genvar i = 0; i < TRIG_W; i++) begin : g_mask
    assign mask[i] = (32'(i) < 32'(rate));
  end

  assign hit = ~|(rnd_trig & mask);
endmodule

// File: rtl/inj_burst_ctl.sv
module inj_burst_ctl
  import inj_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_code,
  input  logic             kind_second,
  input  logic             kind_step,
  input  logic             accept,
  input  logic             kill,
  output logic             in_fill,
  output logic             cur_kind
);
  inj_state_e       state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             kind_q, kind_d;
  logic             upd;

  // next state
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    kind_d  = kind_q;
    upd     = 1'b0;
    unique case (state_q)
      ST_PASS: begin
        if (start && (len_code != '0)) begin
          state_d = ST_FILL;
          rem_d   = len_code;
          kind_d  = kind_second;
          upd     = 1'b1;
        end
      end
      ST_FILL: begin
        if (accept) begin
          upd = 1'b1;
          if (kill || (rem_q == LEN_W'(1))) begin
            state_d = ST_PASS;
            rem_d   = '0;
          end else begin
            rem_d  = rem_q - LEN_W'(1);
            kind_d = kind_step;
          end
        end
      end
      default: state_d = ST_PASS;
    endcase
  end

  // registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PASS;
      rem_q   <= '0;
      kind_q  <= KIND_NOP;
    end else if (upd) begin
      state_q <= state_d;
      rem_q   <= rem_d;
      kind_q  <= kind_d;
    end
  end

  assign in_fill  = (state_q == ST_FILL);
  assign cur_kind = kind_q;

  assert_rem_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_fill |-> (rem_q != '0));
  assert_kill_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill && accept && kill) |=> !in_fill);
  assert_hold_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill && !accept) |=> (in_fill && $stable(kind_q)));
endmodule

// File: rtl/inj_slot_mux.sv
module inj_slot_mux #(
  parameter int          XLEN     = 32,
  parameter int          PC_W     = 32,
  parameter logic [XLEN-1:0] NOP_WORD = 32'h0000_0013,
  parameter logic [XLEN-1:0] BTS_WORD = 32'h0000_006F
) (
  input  logic            fill_sel,
  input  logic            kind,
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_instr,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            dec_ready,
  output logic            fetch_ready,
  output logic            dec_valid,
  output logic [XLEN-1:0] dec_instr,
  output logic [PC_W-1:0] dec_pc
);
  logic [XLEN-1:0] filler_word;

  assign filler_word = kind ? BTS_WORD : NOP_WORD;

  always_comb begin
    if (fill_sel) begin
      dec_valid   = 1'b1;
      dec_instr   = filler_word;
      dec_pc      = fetch_pc;
      fetch_ready = 1'b0;
    end else begin
      dec_valid   = fetch_valid;
      dec_instr   = fetch_instr;
      dec_pc      = fetch_pc;
      fetch_ready = dec_ready;
    end
  end
endmodule

// File: rtl/filler_injector.sv
module filler_injector
  import inj_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              PC_W      = 32,
  parameter int              RATE_W    = 4,
  parameter int              MAX_BURST = 8,
  parameter logic [XLEN-1:0] NOP_WORD  = 32'h0000_0013,
  parameter logic [XLEN-1:0] BTS_WORD  = 32'h0000_006F,
  localparam int TRIG_W  = (1 << RATE_W) - 1,
  localparam int LEN_W   = $clog2(MAX_BURST),
  localparam int LEN_LO  = TRIG_W,
  localparam int KIND_A  = TRIG_W + LEN_W,
  localparam int KIND_B  = TRIG_W + LEN_W + 1,
  localparam int RND_W   = TRIG_W + LEN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [XLEN-1:0]   fetch_instr,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic [RND_W-1:0]  rnd_bits,
  input  logic              inj_en,
  input  logic [RATE_W-1:0] inj_rate,
  input  logic              sleep_req,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [XLEN-1:0]   dec_instr,
  output logic [PC_W-1:0]   dec_pc
);
  logic hit, eligible, start, in_fill, cur_kind, kind_now, fill_sel, accept, kill;

  inj_trigger #(.RATE_W(RATE_W)) u_trig (
    .rate     (inj_rate),
    .rnd_trig (rnd_bits[TRIG_W-1:0]),
    .hit      (hit)
  );

  assign kill     = ~inj_en | sleep_req;
  assign eligible = ~kill & fetch_valid & dec_ready & ~in_fill;
  assign start    = eligible & hit;
  assign accept   = in_fill & dec_ready;
  assign fill_sel = in_fill | start;
  assign kind_now = in_fill ? cur_kind : rnd_bits[KIND_A];

  inj_burst_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .len_code    (rnd_bits[LEN_LO +: LEN_W]),
    .kind_second (rnd_bits[KIND_B]),
    .kind_step   (rnd_bits[KIND_A]),
    .accept      (accept),
    .kill        (kill),
    .in_fill     (in_fill),
    .cur_kind    (cur_kind)
  );

  inj_slot_mux #(
    .XLEN(XLEN), .PC_W(PC_W), .NOP_WORD(NOP_WORD), .BTS_WORD(BTS_WORD)
  ) u_mux (
    .fill_sel    (fill_sel),
    .kind        (kind_now),
    .fetch_valid (fetch_valid),
    .fetch_instr (fetch_instr),
    .fetch_pc    (fetch_pc),
    .dec_ready   (dec_ready),
    .fetch_ready (fetch_ready),
    .dec_valid   (dec_valid),
    .dec_instr   (dec_instr),
    .dec_pc      (dec_pc)
  );

  // slot counter for the burst-length check
  logic [LEN_W:0] slot_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 slot_cnt_q <= '0;
    else if (start)             slot_cnt_q <= (LEN_W+1)'(1);
    else if (accept)            slot_cnt_q <= slot_cnt_q + (LEN_W+1)'(1);
    else if (!in_fill)          slot_cnt_q <= '0;
  end

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt_q <= (LEN_W+1)'(MAX_BURST));
  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_en && !in_fill) |-> (dec_instr == fetch_instr && fetch_ready == dec_ready
                               && dec_valid == fetch_valid));
  assert_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !in_fill) |-> (fetch_ready == dec_ready));
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_fill |-> !fetch_ready);
  assert_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_fill |-> (dec_valid && dec_pc == fetch_pc));
  assert_filler_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_fill |-> (dec_instr == NOP_WORD || dec_instr == BTS_WORD));
  assert_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill && !dec_ready) |=> (in_fill && $stable(dec_instr)));
endmodule

// File: tb/sim_filler_injector.sv
`timescale 1ns/1ps
module sim_filler_injector;
  localparam logic [31:0] NOPW = 32'h0000_0013;
  localparam logic [31:0] BTSW = 32'h0000_006F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid, fetch_ready, inj_en, sleep_req, dec_valid, dec_ready;
  logic [31:0] fetch_instr, fetch_pc, dec_instr, dec_pc;
  logic [19:0] rnd_bits;
  logic [3:0]  inj_rate;

  always #2.5 clk = ~clk;

  filler_injector u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_instr(fetch_instr), .fetch_pc(fetch_pc), .rnd_bits(rnd_bits),
    .inj_en(inj_en), .inj_rate(inj_rate), .sleep_req(sleep_req),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_instr(dec_instr), .dec_pc(dec_pc)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // reference model state
  int rem  = 0;      // remaining filler slots after the presented one (0 = passing)
  bit kind = 0;
  // fetch source state
  logic [31:0] src_pc  = 32'h0000_1000;
  logic [31:0] src_ins = 32'hA5A5_0001;
  bit          src_v   = 0;

  task automatic check(string tag, logic ev, logic [31:0] ei, logic [31:0] ep, logic efr);
    vectors++;
    if (dec_valid !== ev || fetch_ready !== efr ||
        (ev && (dec_instr !== ei || dec_pc !== ep))) begin
      fails++;
      $display("FAIL %s: got v=%0b i=%h pc=%h fr=%0b exp v=%0b i=%h pc=%h fr=%0b",
               tag, dec_valid, dec_instr, dec_pc, fetch_ready, ev, ei, ep, efr);
    end
  endtask

  // one cycle: drive, compare before the edge, advance the model
  task automatic cycle(string tag, bit en, bit slp, int rate, int dr_pct, int fv_pct, int zero_pct);
    logic        ev, efr, start, dr;
    logic [31:0] ei, ep;
    logic [19:0] r;
    @(negedge clk);
    if (!src_v && ($urandom_range(99) < fv_pct)) begin
      src_v = 1; src_ins = $urandom;
    end
    r = 20'($urandom);
    if ($urandom_range(99) < zero_pct) r[14:0] = '0;
    dr = ($urandom_range(99) < dr_pct);
    fetch_valid = src_v; fetch_instr = src_ins; fetch_pc = src_pc;
    inj_en = en; sleep_req = slp; inj_rate = 4'(rate); rnd_bits = r; dec_ready = dr;
    #1;
    start = 0;
    if (rem > 0) begin
      ev = 1; ei = kind ? BTSW : NOPW; ep = src_pc; efr = 0;   // R6 R7
    end else begin
      start = en && !slp && src_v && dr &&
              ((32'(r[14:0]) & ((32'd1 << rate) - 1)) == 0); // R3 R8
      if (start) begin
        ev = 1; ei = r[18] ? BTSW : NOPW; ep = src_pc; efr = 0; // R5
      end else begin
        ev = src_v; ei = src_ins; ep = src_pc; efr = dr;          // R2
      end
    end
    check(tag, ev, ei, ep, efr);
    // advance model (state update at the coming edge)
    if (rem > 0) begin
      if (dr) begin
        if (rem == 1 || !en || slp) rem = 0;                     // R9
        else begin rem = rem - 1; kind = r[18]; end
      end                                                        // R10: hold otherwise
    end else if (start) begin
      if (r[17:15] != 0) begin rem = int'(r[17:15]); kind = r[19]; end // R4
    end else if (src_v && dr) begin
      src_v = 0; src_pc = src_pc + 4;                            // R7 lossless issue
    end
  endtask

  task automatic run(string tag, int n, int en_pct, int slp_pct, int rate,
                     int dr_pct, int fv_pct, int zero_pct);
    for (int i = 0; i < n; i++)
      cycle(tag, ($urandom_range(99) < en_pct), ($urandom_range(99) < slp_pct),
            rate, dr_pct, fv_pct, zero_pct);
  endtask

  initial begin
    rst_n = 0; fetch_valid = 0; fetch_instr = 0; fetch_pc = 0; rnd_bits = 0;
    inj_en = 0; inj_rate = 0; sleep_req = 0; dec_ready = 0;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state, outputs follow the idle fetch side
    vectors++;
    if (dec_valid !== 1'b0 || fetch_ready !== 1'b0) begin
      fails++;
      $display("FAIL R1: got v=%0b fr=%0b exp v=0 fr=0", dec_valid, fetch_ready);
    end
    @(negedge clk); rst_n = 1;
    run("R1", 20, 100, 0, 15, 100, 80, 0);
    run("R2", 400, 0, 0, 0, 70, 80, 0);
    run("R3", 400, 100, 0, 0, 100, 100, 0);
    run("R3", 600, 100, 0, 2, 80, 90, 0);
    run("R3", 600, 100, 0, 15, 90, 90, 0);
    run("R4", 800, 100, 0, 15, 100, 100, 60);
    run("R5", 600, 100, 0, 1, 100, 90, 0);
    run("R6", 400, 100, 0, 3, 90, 100, 0);
    run("R7", 600, 100, 0, 0, 60, 70, 0);
    run("R8", 400, 100, 100, 0, 100, 100, 0);
    run("R9", 1000, 70, 25, 0, 80, 90, 0);
    run("R10", 1000, 100, 0, 1, 40, 90, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule